// File: doc/BRIEF.md
# DRAM Bank Access Timing Scheduler

This block decides when one access to a DRAM bank may start. It keeps three reservation horizons for the chip: the row strobe, the column strobe and the data bus. When a request is accepted, the block computes two bounds. The bank bound is the earliest cycle at which the strobes allow a start. The bus bound is the earliest cycle at which the returning data would find the data bus free. The access is issued at the later of the two. The block then moves the horizons forward and reports three times: the issue cycle, the completion cycle and the expiry time of the open row.

Precharge is folded into auto-precharge commands, so a row left open and a row closed afterwards take the same time. The only difference between them is the row state that gets recorded. A free-running cycle counter measures time. When the counter passes the completion cycle, the block signals completion and names the bank's next action. A pending refresh wins. Otherwise the head of the bank's wait queue is accepted next, and its start is lifted to the row horizon. Otherwise the bank goes idle. Refresh execution, the queue itself and the data-buffer path are outside this block.

The controller has five states:
- IDLE: takes a new request.
- QHEAD: takes the queue head.
- ISSUE: presents the result.
- WAIT: waits for the completion cycle.
- DONE: reports completion and the next action.

The transitions are:
- IDLE→ISSUE and QHEAD→ISSUE on acceptance.
- ISSUE→WAIT after one cycle.
- WAIT→DONE once the counter has reached the completion cycle.
- DONE→IDLE on refresh or an empty queue.
- DONE→QHEAD when a waiter is present.

Top module: `dram_bank_sched`

## Requirements
- R1: `req_ready` is high only in IDLE and QHEAD. A request is taken on `req_valid && req_ready`. `start_valid` is high for exactly the one cycle after acceptance, and `start_cycle` holds the issue cycle in that cycle.
- R2: For a row hit, the bank bound is max(column horizon, arrival) and the bus bound starts as (bus horizon − packet length).
- R3: For a row miss, the bank bound is max(row horizon, column horizon − row-to-column delay, arrival) and the bus bound starts as (bus horizon − row-to-column delay − packet length).
- R4: The bus bound is further reduced by the write latency for a write or by the read latency for a read. The issue cycle is max(bank bound, bus bound). Every subtraction saturates at zero.
- R5: After a hit, the column horizon becomes issue + packet×columns, and the row horizon is unchanged.
- R6: After a miss, the row horizon becomes issue + packet, and the column horizon becomes issue + row-to-column delay + packet×columns.
- R7: The bus horizon, and `done_cycle` with it, becomes column horizon + packet + data latency (write or read). `cmpl_valid` rises for one cycle, in the cycle where `cur_cycle` equals max(`done_cycle`, S+1)+1, with S the value of `cur_cycle` while `start_valid` is high.
- R8: `row_expiry` becomes effective arrival + row hold time when `req_keep` is 1, and 0 otherwise. `hot_row` always takes `req_row`.
- R9: With `cmpl_valid`, `next_act` reads 1 (refresh) if `refresh_pending` is set, else 2 (dequeue) if `wq_nonempty` is set, else 0 (idle). After 1 or 0 the block returns to IDLE. After 2 it enters QHEAD.
- R10: A request accepted in QHEAD uses max(`req_arrival`, row horizon) as its effective arrival. In IDLE the effective arrival is `req_arrival`.
- R11: A request offered while the block is in ISSUE, WAIT or DONE is ignored: `req_ready` stays low, and the horizons and `hot_row` do not change.
- R12: After reset, every horizon, `row_expiry`, `hot_row` and `cur_cycle` are 0, `req_ready` is 1, and `start_valid` and `cmpl_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_pkt | input | PAR_W | Packet length in cycles |
| t_rcd | input | PAR_W | Row-to-column delay |
| t_rdlat | input | PAR_W | Read data latency |
| t_wrlat | input | PAR_W | Write data latency |
| t_hold | input | PAR_W | Row hold time |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_hit | input | 1 | Request targets the open row |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cols | input | COL_W | Number of column packets |
| req_arrival | input | TIME_W | Arrival cycle |
| req_keep | input | 1 | Keep the row open afterwards |
| req_row | input | ROW_W | Row address |
| refresh_pending | input | 1 | Refresh is waiting |
| wq_nonempty | input | 1 | Bank wait queue has a head |
| start_valid | output | 1 | Result valid (one cycle) |
| start_cycle | output | TIME_W | Issue cycle |
| done_cycle | output | TIME_W | Completion cycle |
| row_expiry | output | TIME_W | Open-row expiry time |
| hot_row | output | ROW_W | Last accessed row |
| row_busy | output | TIME_W | Row strobe horizon |
| col_busy | output | TIME_W | Column strobe horizon |
| bus_busy | output | TIME_W | Data bus horizon |
| cur_cycle | output | TIME_W | Free-running cycle counter |
| cmpl_valid | output | 1 | Access complete (one cycle) |
| next_act | output | 2 | Next bank action |

## Verification
The bench keeps the default widths: 32-bit times, 8-bit timing parameters and 4-bit column counts. It runs under two timing sets: packet 2 / delay 3 / read 4 / write 1 / hold 10, and packet 1 / delay 5 / read 2 / write 3 / hold 25. Under each set it sweeps every combination of hit, direction, one to three columns and keep-open. The short latencies make each of the three competing bounds the winner somewhere in the sweep: arrival, strobe horizon and bus horizon. The first accesses after reset drive the saturating subtractions to zero. The choice of which accesses raise a refresh or a queue head reaches all three completion decisions, refresh winning over a waiting head, and the row-horizon lift of a dequeued request.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_QHEAD = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } sched_state_e;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_REFRESH = 2'd1,
        ACT_DEQUEUE = 2'd2
    } next_act_e;

    localparam int HZ_ROW = 0;
    localparam int HZ_COL = 1;
    localparam int HZ_BUS = 2;
    localparam int HZ_NUM = 3;

endpackage

// File: rtl/dbs_start_calc.sv
module dbs_start_calc #(
    parameter int TIME_W = 32,
    parameter int PAR_W  = 8,
    parameter int COL_W  = 4
) (
    input  logic              row_hit,
    input  logic              is_write,
    input  logic [COL_W-1:0]  cols,
    input  logic [TIME_W-1:0] arrival,
    input  logic              keep_open,
    input  logic [PAR_W-1:0]  t_pkt,
    input  logic [PAR_W-1:0]  t_rcd,
    input  logic [PAR_W-1:0]  t_rdlat,
    input  logic [PAR_W-1:0]  t_wrlat,
    input  logic [PAR_W-1:0]  t_hold,
    input  logic [TIME_W-1:0] row_q,
    input  logic [TIME_W-1:0] col_q,
    input  logic [TIME_W-1:0] bus_q,
    output logic [TIME_W-1:0] start_d,
    output logic [TIME_W-1:0] row_d,
    output logic [TIME_W-1:0] col_d,
    output logic [TIME_W-1:0] bus_d,
    output logic [TIME_W-1:0] expiry_d
);

    function automatic logic [TIME_W-1:0] sat_sub(input logic [TIME_W-1:0] a,
                                                  input logic [TIME_W-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    function automatic logic [TIME_W-1:0] later(input logic [TIME_W-1:0] a,
                                                input logic [TIME_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [TIME_W-1:0] pkt, rcd, lat, hold, burst;
    logic [TIME_W-1:0] bank_lim, bus_raw, bus_lim;

    always_comb begin
        pkt   = TIME_W'(t_pkt);
        rcd   = TIME_W'(t_rcd);
        hold  = TIME_W'(t_hold);
        lat   = is_write ? TIME_W'(t_wrlat) : TIME_W'(t_rdlat);
        burst = pkt * TIME_W'(cols);

        if (row_hit) begin
            bank_lim = later(col_q, arrival);
            bus_raw  = sat_sub(bus_q, pkt);
        end else begin
            bank_lim = later(later(row_q, sat_sub(col_q, rcd)), arrival);
            bus_raw  = sat_sub(bus_q, rcd + pkt);
        end
        bus_lim = sat_sub(bus_raw, lat);
        start_d = later(bank_lim, bus_lim);

        if (row_hit) begin
            row_d = row_q;
            col_d = start_d + burst;
        end else begin
            row_d = start_d + pkt;
            col_d = start_d + rcd + burst;
        end
        bus_d    = col_d + pkt + lat;
        expiry_d = keep_open ? (arrival + hold) : '0;
    end

endmodule

// File: rtl/dbs_horizons.sv
module dbs_horizons #(
    parameter int TIME_W = 32,
    parameter int NUM    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NUM-1:0][TIME_W-1:0]  hz_d,
    output logic [NUM-1:0][TIME_W-1:0]  hz_q
);

    for (genvar g = 0; g < NUM; g++) begin : g_hz
        always_ff @(posedge clk) begin
            if (!rst_n)
                hz_q[g] <= '0;
            else if (load)
                hz_q[g] <= hz_d[g];
        end

        // R5 R6: a reservation horizon never moves backwards
        horizon_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hz_q[g] >= $past(hz_q[g]));
    end

endmodule

// File: rtl/dbs_fsm.sv
module dbs_fsm
    import dbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       time_reached,
    input  logic       refresh_pending,
    input  logic       wq_nonempty,
    output logic       req_ready,
    output logic       accept,
    output logic       from_queue,
    output logic       start_valid,
    output logic       cmpl_valid,
    output next_act_e  next_act
);

    sched_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_QHEAD: if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (time_reached) state_d = ST_DONE;
            ST_DONE: begin
                if (refresh_pending)  state_d = ST_IDLE;
                else if (wq_nonempty) state_d = ST_QHEAD;
                else                  state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready   = (state_q == ST_IDLE) || (state_q == ST_QHEAD);
        accept      = req_ready && req_valid;
        from_queue  = (state_q == ST_QHEAD);
        start_valid = (state_q == ST_ISSUE);
        cmpl_valid  = (state_q == ST_DONE);
        next_act    = ACT_IDLE;
        if (state_q == ST_DONE) begin
            if (refresh_pending)  next_act = ACT_REFRESH;
            else if (wq_nonempty) next_act = ACT_DEQUEUE;
        end
    end

    // R1
    start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> $past(req_valid));

    // R1
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> !start_valid);

    // R7
    cmpl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> !cmpl_valid);

    // R9
    refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && refresh_pending) |=> !from_queue);

endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
    import dbs_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int PAR_W  = 8,
    parameter int COL_W  = 4,
    parameter int ROW_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAR_W-1:0]  t_pkt,
    input  logic [PAR_W-1:0]  t_rcd,
    input  logic [PAR_W-1:0]  t_rdlat,
    input  logic [PAR_W-1:0]  t_wrlat,
    input  logic [PAR_W-1:0]  t_hold,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_hit,
    input  logic              req_write,
    input  logic [COL_W-1:0]  req_cols,
    input  logic [TIME_W-1:0] req_arrival,
    input  logic              req_keep,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              refresh_pending,
    input  logic              wq_nonempty,
    output logic              start_valid,
    output logic [TIME_W-1:0] start_cycle,
    output logic [TIME_W-1:0] done_cycle,
    output logic [TIME_W-1:0] row_expiry,
    output logic [ROW_W-1:0]  hot_row,
    output logic [TIME_W-1:0] row_busy,
    output logic [TIME_W-1:0] col_busy,
    output logic [TIME_W-1:0] bus_busy,
    output logic [TIME_W-1:0] cur_cycle,
    output logic              cmpl_valid,
    output logic [1:0]        next_act
);

    logic                         accept, from_queue, time_reached;
    next_act_e                    act_e;
    logic [TIME_W-1:0]            eff_arr, arr_q;
    logic [TIME_W-1:0]            start_d, row_d, col_d, bus_d, expiry_d;
    logic [HZ_NUM-1:0][TIME_W-1:0] hz_d, hz_q;
    logic [TIME_W-1:0]            now_q, start_q, done_q, expiry_q;
    logic [ROW_W-1:0]             hot_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            now_q <= '0;
        else
            now_q <= now_q + 1'b1;
    end

    assign time_reached = (now_q >= done_q);
    assign eff_arr = (from_queue && (hz_q[HZ_ROW] > req_arrival)) ? hz_q[HZ_ROW] : req_arrival;

    dbs_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .time_reached    (time_reached),
        .refresh_pending (refresh_pending),
        .wq_nonempty     (wq_nonempty),
        .req_ready       (req_ready),
        .accept          (accept),
        .from_queue      (from_queue),
        .start_valid     (start_valid),
        .cmpl_valid      (cmpl_valid),
        .next_act        (act_e)
    );

    dbs_start_calc #(.TIME_W(TIME_W), .PAR_W(PAR_W), .COL_W(COL_W)) u_calc (
        .row_hit   (req_hit),
        .is_write  (req_write),
        .cols      (req_cols),
        .arrival   (eff_arr),
        .keep_open (req_keep),
        .t_pkt     (t_pkt),
        .t_rcd     (t_rcd),
        .t_rdlat   (t_rdlat),
        .t_wrlat   (t_wrlat),
        .t_hold    (t_hold),
        .row_q     (hz_q[HZ_ROW]),
        .col_q     (hz_q[HZ_COL]),
        .bus_q     (hz_q[HZ_BUS]),
        .start_d   (start_d),
        .row_d     (row_d),
        .col_d     (col_d),
        .bus_d     (bus_d),
        .expiry_d  (expiry_d)
    );

    always_comb begin
        hz_d[HZ_ROW] = row_d;
        hz_d[HZ_COL] = col_d;
        hz_d[HZ_BUS] = bus_d;
    end

    dbs_horizons #(.TIME_W(TIME_W), .NUM(HZ_NUM)) u_hz (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .hz_d  (hz_d),
        .hz_q  (hz_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            done_q   <= '0;
            expiry_q <= '0;
            hot_q    <= '0;
            arr_q    <= '0;
        end else if (accept) begin
            start_q  <= start_d;
            done_q   <= bus_d;
            expiry_q <= expiry_d;
            hot_q    <= req_row;
            arr_q    <= eff_arr;
        end
    end

    always_comb begin
        start_cycle = start_q;
        done_cycle  = done_q;
        row_expiry  = expiry_q;
        hot_row     = hot_q;
        row_busy    = hz_q[HZ_ROW];
        col_busy    = hz_q[HZ_COL];
        bus_busy    = hz_q[HZ_BUS];
        cur_cycle   = now_q;
        next_act    = act_e;
    end

    // R2 R3
    start_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> start_cycle >= arr_q);

    // R7
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> done_cycle >= start_cycle);

    // R7
    cmpl_late_enough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |-> cur_cycle > done_cycle);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ($stable(bus_busy) && $stable(hot_row)));

endmodule

// File: tb/dram_bank_sched_tb.sv
module dram_bank_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 32;
    localparam int PW = 8;
    localparam int CW = 4;
    localparam int RW = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [PW-1:0] t_pkt, t_rcd, t_rdlat, t_wrlat, t_hold;
    logic          req_valid, req_ready, req_hit, req_write, req_keep;
    logic [CW-1:0] req_cols;
    logic [TW-1:0] req_arrival;
    logic [RW-1:0] req_row;
    logic          refresh_pending, wq_nonempty;
    logic          start_valid, cmpl_valid;
    logic [TW-1:0] start_cycle, done_cycle, row_expiry, row_busy, col_busy, bus_busy, cur_cycle;
    logic [RW-1:0] hot_row;
    logic [1:0]    next_act;

    int checks = 0;
    int errors = 0;
    logic [TW-1:0] m_row = '0, m_col = '0, m_bus = '0;
    int m_act = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_bank_sched u_dut (
        .clk(clk), .rst_n(rst_n),
        .t_pkt(t_pkt), .t_rcd(t_rcd), .t_rdlat(t_rdlat), .t_wrlat(t_wrlat), .t_hold(t_hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_hit(req_hit), .req_write(req_write),
        .req_cols(req_cols), .req_arrival(req_arrival), .req_keep(req_keep), .req_row(req_row),
        .refresh_pending(refresh_pending), .wq_nonempty(wq_nonempty),
        .start_valid(start_valid), .start_cycle(start_cycle), .done_cycle(done_cycle),
        .row_expiry(row_expiry), .hot_row(hot_row), .row_busy(row_busy), .col_busy(col_busy),
        .bus_busy(bus_busy), .cur_cycle(cur_cycle), .cmpl_valid(cmpl_valid), .next_act(next_act)
    );

    task automatic check_val(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] mx(input logic [TW-1:0] a, input logic [TW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [TW-1:0] sub0(input logic [TW-1:0] a, input logic [TW-1:0] b);
        return (a > b) ? a - b : 0;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic run_access(input bit hit, input bit wr, input int cols, input logic [TW-1:0] arr,
                              input bit keep, input logic [RW-1:0] row, input bit refr,
                              input bit wq, input bit poke);
        logic [TW-1:0] p, d, l, e_arr, bank, busl, e_start, e_row, e_col, e_bus, e_exp, s_cyc;
        bit from_q;
        int e_act;
        from_q = (m_act == 2);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_hit = hit; req_write = wr; req_cols = CW'(cols); req_arrival = arr;
        req_keep = keep; req_row = row; req_valid = 1'b1;
        refresh_pending = refr; wq_nonempty = wq;
        p = TW'(t_pkt); d = TW'(t_rcd); l = wr ? TW'(t_wrlat) : TW'(t_rdlat);
        e_arr = from_q ? mx(arr, m_row) : arr;
        if (hit) begin
            bank = mx(m_col, e_arr);
            busl = sub0(sub0(m_bus, p), l);
        end else begin
            bank = mx(mx(m_row, sub0(m_col, d)), e_arr);
            busl = sub0(sub0(m_bus, d + p), l);
        end
        e_start = mx(bank, busl);
        e_row = hit ? m_row : e_start + p;
        e_col = hit ? e_start + p * TW'(cols) : e_start + d + p * TW'(cols);
        e_bus = e_col + p + l;
        e_exp = keep ? e_arr + TW'(t_hold) : 0;
        @(negedge clk);
        req_valid = 1'b0;
        check_val("R1 start_valid", TW'(start_valid), 1);
        check_val(from_q ? "R10 start_cycle" : (hit ? "R2/R4 start_cycle" : "R3/R4 start_cycle"),
                  start_cycle, e_start);
        check_val("R7 done_cycle", done_cycle, e_bus);
        check_val(hit ? "R5 row_busy" : "R6 row_busy", row_busy, e_row);
        check_val(hit ? "R5 col_busy" : "R6 col_busy", col_busy, e_col);
        check_val("R7 bus_busy", bus_busy, e_bus);
        check_val("R8 row_expiry", row_expiry, e_exp);
        check_val("R8 hot_row", TW'(hot_row), TW'(row));
        s_cyc = cur_cycle;
        m_row = e_row; m_col = e_col; m_bus = e_bus;
        if (poke) begin
            req_valid = 1'b1; req_row = ~row; req_hit = ~hit; req_arrival = 0;
        end
        @(negedge clk);
        check_val("R1 start_valid pulse", TW'(start_valid), 0);
        if (poke) check_val("R11 req_ready while busy", TW'(req_ready), 0);
        while (!cmpl_valid) @(negedge clk);
        req_valid = 1'b0;
        e_act = refr ? 1 : (wq ? 2 : 0);
        check_val("R7 completion cycle", cur_cycle, mx(e_bus, s_cyc + 1) + 1);
        check_val("R9 next_act", TW'(next_act), TW'(e_act));
        if (poke) begin
            check_val("R11 bus_busy untouched", bus_busy, m_bus);
            check_val("R11 hot_row untouched", TW'(hot_row), TW'(row));
        end
        m_act = e_act;
        @(negedge clk);
        check_val("R9 ready after completion", TW'(req_ready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 0; req_hit = 0; req_write = 0; req_cols = 0; req_arrival = 0;
        req_keep = 0; req_row = 0; refresh_pending = 0; wq_nonempty = 0;
        t_pkt = 8'd2; t_rcd = 8'd3; t_rdlat = 8'd4; t_wrlat = 8'd1; t_hold = 8'd10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R12 req_ready", TW'(req_ready), 1);
        check_val("R12 start_valid", TW'(start_valid), 0);
        check_val("R12 cmpl_valid", TW'(cmpl_valid), 0);
        check_val("R12 row_busy", row_busy, 0);
        check_val("R12 col_busy", col_busy, 0);
        check_val("R12 bus_busy", bus_busy, 0);
        check_val("R12 row_expiry", row_expiry, 0);
        check_val("R12 hot_row", TW'(hot_row), 0);
        check_val("R12 cur_cycle", cur_cycle, 1);

        for (int ts = 0; ts < 2; ts++) begin
            if (ts == 1) begin
                t_pkt = 8'd1; t_rcd = 8'd5; t_rdlat = 8'd2; t_wrlat = 8'd3; t_hold = 8'd25;
            end
            for (int idx = 0; idx < 24; idx++) begin
                logic [TW-1:0] arr;
                arr = (idx % 3 == 0) ? cur_cycle + 30 : ((idx % 3 == 1) ? 0 : cur_cycle);
                run_access(idx[0], idx[1], (idx / 4) % 3 + 1, arr, idx >= 12,
                           RW'(idx * 37 + ts), (idx % 7) == 3, (idx % 5) == 2, idx == 5);
            end
        end
        summary();
        $finish;
    end

endmodule